// File: doc/BRIEF.md
# Quasi-Resonant Valley Selector

After a flyback switch turns off, the switch node rings. This block decides in which valley of that ringing the switch may turn on again. It counts valleys after each falling edge of the gate. A valley is either a real one, seen as the zero-crossing comparator dropping below its threshold, or a substitute one made by a timeout when the comparator stays low. When the count reaches the target valley, the block raises a one-cycle turn-on request.

The target valley comes from two inputs: the line range and the active dimming step. The line range is taken from a digitized input-voltage code through a hysteretic comparator with separate rising and falling thresholds. A new target is applied only at the rising edge of the gate, which is the start of a switching cycle. The selector therefore stays locked in one valley during a cycle and does not jump between valleys when the line sits near a threshold.

Top module: `qr_valley_sel`

## Requirements
- R1: While reset is held and on the first cycle after it, `turn_on_req` is 0, `valley_cnt` is 0 and `valley_idx` is 1.
- R2: While armed (gate low, no request issued since the last gate fall), each 0-to-1 transition of `zcd_below` (1 means the ringing is below the threshold) adds one to `valley_cnt`. The new count is visible on the cycle after the edge is sampled.
- R3: If `zcd_below` stays 1 for `TMO_CYC` clocks after a real or substitute valley, a substitute valley is counted, and the timeout restarts from that valley. With the defaults this is 325 clocks, which is 6.5 µs at 50 MHz.
- R4: When the count reaches `valley_idx`, `turn_on_req` is 1 for exactly one cycle. Counting then stops, and later valleys change neither the count nor the request until the next gate fall.
- R5: While `gate_on` is 1, no valley is counted, `valley_cnt` reads 0 on the following cycle and no request is made. A gate fall re-arms counting from 0.
- R6: In the low line range, dim steps 0 to 5 select valleys 1, 2, 4, 7, 11 and 13. Step values above 5 act as step 5.
- R7: In the high line range, dim steps 0 to 5 select valleys 2, 3, 5, 8, 12 and 15.
- R8: The range goes from low to high when `line_code` >= `LINE_UP` (default 160). It returns to low when `line_code` < `LINE_DN` (default 140). Between the two thresholds the range holds.
- R9: `valley_idx` changes only on the cycle after `gate_on` is first sampled high. Changes of line or dim step while the gate is low have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zcd_below | input | 1 | Synchronized comparator output, 1 when the ringing is below the threshold |
| line_code | input | LINE_W | Digitized input-voltage level |
| dim_step | input | 3 | Active dimming step, 0 is undimmed |
| gate_on | input | 1 | Switch gate state, 1 while the switch is on |
| turn_on_req | output | 1 | One-cycle turn-on request at the selected valley |
| valley_idx | output | 4 | Valley number in use for the current cycle |
| valley_cnt | output | 4 | Valleys counted since the last gate fall |

## Verification
The bench counts valleys one at a time against targets from both tables. It checks that the request appears at the target valley and nowhere else. A design that counted the rising comparator edge, or kept counting after the request, would fire early or in the wrong place.

In the dropped-valley case the comparator is held low, and the substitute valley must appear exactly `TMO_CYC` clocks after the real one. An off-by-one timeout, or one that never restarts, would shift the request.

Line sweeps up and down through the band between the two thresholds check that the range holds inside the band. A plain comparator in place of the hysteretic one would flip the valley inside the band. Line and dim changes made mid-cycle must leave `valley_idx` untouched until the next gate rise.

// File: rtl/qr_valley_pkg.sv
package qr_valley_pkg;

    typedef enum logic {
        RANGE_LOW  = 1'b0,
        RANGE_HIGH = 1'b1
    } line_range_e;

    typedef struct packed {
        line_range_e rng;
        logic [2:0]  pos;
    } valley_sel_t;

    localparam int unsigned VALLEY_W = 4;
    localparam logic [2:0]  LAST_POS = 3'd5;

    // Valley number for a line range and dimming position.
    function automatic logic [VALLEY_W-1:0] valley_for(valley_sel_t sel);
        logic [2:0]          p;
        logic [VALLEY_W-1:0] v;
        p = (sel.pos > LAST_POS) ? LAST_POS : sel.pos;
        if (sel.rng == RANGE_LOW) begin
            case (p)
                3'd0:    v = 4'd1;
                3'd1:    v = 4'd2;
                3'd2:    v = 4'd4;
                3'd3:    v = 4'd7;
                3'd4:    v = 4'd11;
                default: v = 4'd13;
            endcase
        end else begin
            case (p)
                3'd0:    v = 4'd2;
                3'd1:    v = 4'd3;
                3'd2:    v = 4'd5;
                3'd3:    v = 4'd8;
                3'd4:    v = 4'd12;
                default: v = 4'd15;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/qr_line_hyst.sv
module qr_line_hyst
    import qr_valley_pkg::*;
#(
    parameter int unsigned         LINE_W  = 8,
    parameter logic [LINE_W-1:0]   LINE_UP = LINE_W'(160),
    parameter logic [LINE_W-1:0]   LINE_DN = LINE_W'(140)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_code,
    output line_range_e       rng
);

    line_range_e rng_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_q <= RANGE_LOW;
        end else if (rng_q == RANGE_LOW && line_code >= LINE_UP) begin
            rng_q <= RANGE_HIGH;
        end else if (rng_q == RANGE_HIGH && line_code < LINE_DN) begin
            rng_q <= RANGE_LOW;
        end
    end

    assign rng = rng_q;

    // R8: entering the high range needs a code at or above the upper threshold
    a_r8_enter_high: assert property (@(posedge clk) disable iff (rst)
        (rng_q == RANGE_HIGH && $past(rng_q) == RANGE_LOW) |-> $past(line_code) >= LINE_UP);

    // R8: leaving the high range needs a code below the lower threshold
    a_r8_leave_high: assert property (@(posedge clk) disable iff (rst)
        (rng_q == RANGE_LOW && $past(rng_q) == RANGE_HIGH) |-> $past(line_code) < LINE_DN);

endmodule

// File: rtl/qr_valley_target.sv
module qr_valley_target
    import qr_valley_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  line_range_e         rng,
    input  logic [2:0]          dim_step,
    input  logic                cycle_start,
    output logic [VALLEY_W-1:0] target
);

    valley_sel_t         sel;
    logic [VALLEY_W-1:0] target_q;

    always_comb begin
        sel.rng = rng;
        sel.pos = dim_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= 4'd1;
        end else if (cycle_start) begin
            target_q <= valley_for(sel);
        end
    end

    assign target = target_q;

    // R6/R7: the applied valley is never zero
    a_r6_target_nonzero: assert property (@(posedge clk) disable iff (rst)
        target_q != 4'd0);

endmodule

// File: rtl/qr_valley_timeout.sv
module qr_valley_timeout #(
    parameter int unsigned TMO_CYC = 325
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic zcd_below,
    output logic valley_evt
);

    localparam int unsigned TW = $clog2(TMO_CYC + 1);

    logic          zcd_q;
    logic [TW-1:0] tcnt;
    logic          real_edge;
    logic          sub_pulse;

    assign real_edge  = enable && zcd_below && !zcd_q;
    assign sub_pulse  = enable && zcd_below && !real_edge && (tcnt == TW'(TMO_CYC - 1));
    assign valley_evt = real_edge || sub_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            zcd_q <= 1'b0;
            tcnt  <= '0;
        end else begin
            zcd_q <= zcd_below;
            if (!enable || !zcd_below || valley_evt) begin
                tcnt <= '0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R3: the timeout counter never passes its limit
    a_r3_tcnt_bound: assert property (@(posedge clk) disable iff (rst)
        tcnt < TW'(TMO_CYC));

    // R3: a substitute valley only appears while the comparator stays low
    a_r3_sub_when_low: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |-> ($past(zcd_below) && zcd_below));

endmodule

// File: rtl/qr_valley_counter.sv
module qr_valley_counter
    import qr_valley_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_on,
    input  logic                valley_evt,
    input  logic [VALLEY_W-1:0] target,
    output logic                armed,
    output logic                cycle_start,
    output logic                req,
    output logic [VALLEY_W-1:0] cnt
);

    logic                gate_q;
    logic                gate_fall;
    logic [VALLEY_W-1:0] cnt_inc;

    assign cycle_start = gate_on && !gate_q;
    assign gate_fall   = gate_q && !gate_on;
    assign cnt_inc     = cnt + 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            armed  <= 1'b1;
            req    <= 1'b0;
            cnt    <= '0;
        end else begin
            gate_q <= gate_on;
            req    <= 1'b0;
            if (gate_on) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (gate_fall) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && valley_evt) begin
                cnt <= cnt_inc;
                if (cnt_inc >= target) begin
                    req   <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end

    // R4: request lasts a single cycle
    a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R5: a high gate clears the count and blocks the request
    a_r5_gate_clears: assert property (@(posedge clk) disable iff (rst)
        $past(gate_on) |-> (cnt == 4'd0 && !req));

    // R2: the count only steps by one or returns to zero
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 4'd1 || cnt == 4'd0));

endmodule

// File: rtl/qr_valley_sel.sv
module qr_valley_sel
    import qr_valley_pkg::*;
#(
    parameter int unsigned       LINE_W  = 8,
    parameter logic [LINE_W-1:0] LINE_UP = LINE_W'(160),
    parameter logic [LINE_W-1:0] LINE_DN = LINE_W'(140),
    parameter int unsigned       TMO_CYC = 325
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zcd_below,
    input  logic [LINE_W-1:0] line_code,
    input  logic [2:0]        dim_step,
    input  logic              gate_on,
    output logic              turn_on_req,
    output logic [3:0]        valley_idx,
    output logic [3:0]        valley_cnt
);

    line_range_e         rng;
    logic [VALLEY_W-1:0] target;
    logic                cycle_start;
    logic                armed;
    logic                valley_evt;

    qr_line_hyst #(
        .LINE_W  (LINE_W),
        .LINE_UP (LINE_UP),
        .LINE_DN (LINE_DN)
    ) u_hyst (
        .clk       (clk),
        .rst       (rst),
        .line_code (line_code),
        .rng       (rng)
    );

    qr_valley_target u_target (
        .clk         (clk),
        .rst         (rst),
        .rng         (rng),
        .dim_step    (dim_step),
        .cycle_start (cycle_start),
        .target      (target)
    );

    qr_valley_timeout #(
        .TMO_CYC (TMO_CYC)
    ) u_tmo (
        .clk        (clk),
        .rst        (rst),
        .enable     (armed),
        .zcd_below  (zcd_below),
        .valley_evt (valley_evt)
    );

    qr_valley_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .gate_on     (gate_on),
        .valley_evt  (valley_evt),
        .target      (target),
        .armed       (armed),
        .cycle_start (cycle_start),
        .req         (turn_on_req),
        .cnt         (valley_cnt)
    );

    assign valley_idx = target;

    // R9: the applied valley moves only right after a gate rise
    a_r9_locked: assert property (@(posedge clk) disable iff (rst)
        !$stable(valley_idx) |-> $past(cycle_start));

    // R4: the count never runs past the applied valley
    a_r4_cnt_le_target: assert property (@(posedge clk) disable iff (rst)
        valley_cnt <= valley_idx);

endmodule

// File: tb/test_qr_valley_sel.sv
module test_qr_valley_sel;

    localparam int TMO = 325;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zcd_below = 1'b0;
    logic [7:0] line_code = 8'd100;
    logic [2:0] dim_step = 3'd0;
    logic       gate_on = 1'b0;
    logic       turn_on_req;
    logic [3:0] valley_idx;
    logic [3:0] valley_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    qr_valley_sel i_qr_valley_sel (
        .clk         (clk),
        .rst         (rst),
        .zcd_below   (zcd_below),
        .line_code   (line_code),
        .dim_step    (dim_step),
        .gate_on     (gate_on),
        .turn_on_req (turn_on_req),
        .valley_idx  (valley_idx),
        .valley_cnt  (valley_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Gate pulse: starts a switching cycle, then re-arms on the fall
    task automatic gate_pulse();
        @(negedge clk) gate_on = 1'b1;
        repeat (3) @(negedge clk);
        gate_on = 1'b0;
        @(negedge clk);
    endtask

    // One real valley, checking request and count right after it
    task automatic valley(input string tag, input int exp_req, input int exp_cnt);
        @(negedge clk) zcd_below = 1'b1;
        @(negedge clk);
        check({tag, " req"}, int'(turn_on_req), exp_req);
        check({tag, " cnt"}, int'(valley_cnt), exp_cnt);
        zcd_below = 1'b0;
        @(negedge clk);
        check({tag, " req drop R4"}, int'(turn_on_req), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset req", int'(turn_on_req), 0);
        check("R1 reset idx", int'(valley_idx), 1);
        check("R1 reset cnt", int'(valley_cnt), 0);
    endtask

    task automatic t_normal();
        dim_step = 3'd0; line_code = 8'd100;
        gate_pulse();
        check("R6 low step0", int'(valley_idx), 1);
        valley("R2 R4 first valley", 1, 1);
        valley("R4 halted after req", 0, 1);
        dim_step = 3'd3;
        repeat (2) @(negedge clk);
        check("R9 idx held mid-cycle", int'(valley_idx), 1);
        gate_pulse();
        check("R6 low step3", int'(valley_idx), 7);
        for (int i = 1; i <= 7; i++) valley("R2 R4 count to 7", (i == 7) ? 1 : 0, i);
        valley("R4 no count after req", 0, 7);
        dim_step = 3'd7;
        gate_pulse();
        check("R6 clamp step7", int'(valley_idx), 13);
    endtask

    task automatic t_drop();
        dim_step = 3'd2; line_code = 8'd100;
        gate_pulse();
        check("R6 low step2", int'(valley_idx), 4);
        valley("R2 drop v1", 0, 1);
        @(negedge clk) zcd_below = 1'b1;
        @(negedge clk);
        check("R2 drop v2 cnt", int'(valley_cnt), 2);
        repeat (TMO - 1) @(negedge clk);
        check("R3 before timeout", int'(valley_cnt), 2);
        @(negedge clk);
        check("R3 substitute valley", int'(valley_cnt), 3);
        repeat (TMO - 1) @(negedge clk);
        check("R3 restart before", int'(valley_cnt), 3);
        @(negedge clk);
        check("R3 R4 second substitute hits target", int'(turn_on_req), 1);
        check("R3 second substitute cnt", int'(valley_cnt), 4);
        zcd_below = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_gate_block();
        dim_step = 3'd0;
        @(negedge clk) gate_on = 1'b1;
        @(negedge clk) zcd_below = 1'b1;
        @(negedge clk);
        check("R5 no count while gate high", int'(valley_cnt), 0);
        check("R5 no req while gate high", int'(turn_on_req), 0);
        zcd_below = 1'b0;
        @(negedge clk) gate_on = 1'b0;
        @(negedge clk);
        check("R5 rearmed cnt", int'(valley_cnt), 0);
        valley("R5 counts after fall", 1, 1);
    endtask

    task automatic t_line();
        dim_step = 3'd0;
        line_code = 8'd150; repeat (2) @(negedge clk); gate_pulse();
        check("R8 inside band from low", int'(valley_idx), 1);
        line_code = 8'd160; repeat (2) @(negedge clk);
        check("R9 line change held", int'(valley_idx), 1);
        gate_pulse();
        check("R7 R8 enter high", int'(valley_idx), 2);
        line_code = 8'd150; repeat (2) @(negedge clk); gate_pulse();
        check("R8 inside band from high", int'(valley_idx), 2);
        line_code = 8'd140; repeat (2) @(negedge clk); gate_pulse();
        check("R8 at lower threshold", int'(valley_idx), 2);
        line_code = 8'd139; repeat (2) @(negedge clk); gate_pulse();
        check("R8 leave high", int'(valley_idx), 1);
        line_code = 8'd200; dim_step = 3'd4; repeat (2) @(negedge clk); gate_pulse();
        check("R7 high step4", int'(valley_idx), 12);
        valley("R7 high count 1", 0, 1);
        dim_step = 3'd5; gate_pulse();
        check("R7 high step5", int'(valley_idx), 15);
        dim_step = 3'd1; gate_pulse();
        check("R7 high step1", int'(valley_idx), 3);
        valley("R7 step1 v1", 0, 1);
        valley("R7 step1 v2", 0, 2);
        valley("R7 step1 v3", 1, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_drop();
        t_gate_block();
        t_line();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule